// File: doc/BRIEF.md
# Configurable Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. From a runtime baud divisor it makes its own sampling tick, running at sixteen ticks per bit, so one bit lasts `16 * divisor_i` reference clocks. A 125 MHz reference with a divisor of 68 gives roughly 115200 baud. The line passes through a two-flop synchronizer. The falling edge that starts a frame is confirmed half a bit later, and every later bit is sampled in the middle of its bit period.

The frame format is chosen at run time. It sets one or two stop bits, seven or eight data bits, and a parity mode. When a good byte arrives, the block emits a one-cycle push strobe with the byte, ready for a receive FIFO. Bad frames and bytes that the FIFO cannot take produce one-cycle event pulses instead, which go to an interrupt unit. The FIFO, the transmitter and the register interface are separate blocks.

Top module: `uart_rx_core`

## Requirements
- R1: While rst_ni is low and after its release with an idle (high) line, push_o, frame_err_o, parity_err_o and overflow_o stay 0 and data_o is 0.
- R2: With word7_i=0, a frame is made of a low start bit, eight data bits sent least significant first, optional parity and stop bits. Each bit lasts 16*divisor_i clocks. A good frame gives exactly one push_o pulse carrying the byte, and data_o changes only on a push.
- R3: With word7_i=1, only seven data bits are received and the pushed byte has bit 7 equal to 0.
- R4: With stop_two_i=1, two high stop bits are required: a low second stop bit is a framing error. With stop_two_i=0, the frame ends after one stop bit.
- R5: parity_sel_i=3'b001 (odd) expects the data bits plus the parity bit to hold an odd number of ones. 3'b010 (even) expects an even number.
- R6: parity_sel_i=3'b011 expects the parity bit to be 1, and 3'b100 expects it to be 0.
- R7: parity_sel_i=3'b000 and the unused codes 3'b101 to 3'b111 mean that no parity bit is present.
- R8: A low stop bit gives one frame_err_o pulse and no push. This error takes precedence over a parity error in the same frame.
- R9: A parity mismatch in a frame whose stop bits are good gives one parity_err_o pulse and no push.
- R10: A good frame that completes while fifo_full_i is 1 gives one overflow_o pulse and no push. A push never happens while the FIFO is full.
- R11: A low pulse shorter than half a bit, which is high again at the mid-start sample, is rejected and produces no output at all.
- R12: Every event output is a single-cycle pulse, and at most one of push_o, frame_err_o, parity_err_o and overflow_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| divisor_i | input | 12 | Baud divisor, reference clocks per sampling tick |
| stop_two_i | input | 1 | 0: one stop bit, 1: two stop bits |
| word7_i | input | 1 | 0: eight data bits, 1: seven data bits |
| parity_sel_i | input | 3 | Parity mode code |
| fifo_full_i | input | 1 | Receive FIFO cannot accept a byte |
| push_o | output | 1 | One-cycle strobe to write data_o into the FIFO |
| data_o | output | 8 | Last good byte received |
| frame_err_o | output | 1 | One-cycle framing-error event |
| parity_err_o | output | 1 | One-cycle parity-error event |
| overflow_o | output | 1 | One-cycle receive-overflow event |

## Verification
The assertions assume that the format inputs (word7_i in particular) stay constant while a frame is in flight, and that frames are far enough apart that no two events fall in neighbouring cycles. The stimulus changes the divisor, the format and the FIFO-full level only while the line is idle between frames. It uses divisors of 1 to 4, never 0, and ends every frame with two idle bit periods. Random frames mix all parity codes, both word sizes and both stop settings with injected parity, stop and overflow faults. Directed frames cover the glitch start and each mode on its own.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam logic [2:0] PAR_NONE  = 3'b000;
  localparam logic [2:0] PAR_ODD   = 3'b001;
  localparam logic [2:0] PAR_EVEN  = 3'b010;
  localparam logic [2:0] PAR_MARK  = 3'b011;
  localparam logic [2:0] PAR_SPACE = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  function automatic logic par_present(input logic [2:0] sel);
    return (sel == PAR_ODD) || (sel == PAR_EVEN) || (sel == PAR_MARK) || (sel == PAR_SPACE);
  endfunction

  // acc: xor of received data bits, pbit: received parity bit
  function automatic logic par_match(input logic [2:0] sel, input logic acc, input logic pbit);
    logic ok;
    case (sel)
      PAR_ODD:   ok = (acc ^ pbit) == 1'b1;
      PAR_EVEN:  ok = (acc ^ pbit) == 1'b0;
      PAR_MARK:  ok = pbit;
      PAR_SPACE: ok = !pbit;
      default:   ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES:0] q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[g] <= 1'b1;
        else         q[g] <= rx_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[g] <= 1'b1;
        else         q[g] <= q[g-1];
      end
    end
  end

  assign line_o = q[STAGES-1];
  assign fall_o = q[STAGES] & ~q[STAGES-1];

endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] term;

  // divisor 0 behaves as 1
  assign term   = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick_o = !clr_i && (cnt >= term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt <= '0;
    else if (clr_i)        cnt <= '0;
    else if (cnt >= term)  cnt <= '0;
    else                   cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              tick_i,
  input  logic              stop_two_i,
  input  logic              word7_i,
  input  logic [2:0]        parity_sel_i,
  input  logic              fifo_full_i,
  output logic              busy_o,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              overflow_o
);

  localparam int unsigned OSR_W = $clog2(OSR);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [OSR_W-1:0] OS_MID  = OSR_W'(OSR/2 - 1);
  localparam logic [OSR_W-1:0] OS_LAST = OSR_W'(OSR - 1);

  rx_state_e         state;
  logic [OSR_W-1:0]  os_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [BIT_W-1:0]  last_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              par_bad;
  logic              stop_bad;
  logic              sample;
  logic              mid_hit;
  logic              done;
  logic              done_fe;
  logic              good;

  assign busy_o   = (state != ST_IDLE);
  assign sample   = tick_i && (os_cnt == OS_LAST);
  assign mid_hit  = tick_i && (os_cnt == OS_MID);
  assign last_idx = word7_i ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);
  assign done     = sample && ((state == ST_STOP1 && !stop_two_i) || state == ST_STOP2);
  assign done_fe  = stop_bad || !line_i;
  assign good     = done && !done_fe && !par_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      os_cnt   <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      if (tick_i) os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + OSR_W'(1);
      case (state)
        ST_IDLE: begin
          os_cnt <= '0;
          if (fall_i) begin
            state    <= ST_START;
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
          end
        end
        ST_START: begin
          if (mid_hit) begin
            os_cnt <= '0;
            state  <= line_i ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (sample) begin
            shreg[bit_idx] <= line_i;
            par_acc        <= par_acc ^ line_i;
            if (bit_idx == last_idx) state <= par_present(parity_sel_i) ? ST_PAR : ST_STOP1;
            else                     bit_idx <= bit_idx + BIT_W'(1);
          end
        end
        ST_PAR: begin
          if (sample) begin
            par_bad <= !par_match(parity_sel_i, par_acc, line_i);
            state   <= ST_STOP1;
          end
        end
        ST_STOP1: begin
          if (sample) begin
            stop_bad <= !line_i;
            state    <= stop_two_i ? ST_STOP2 : ST_IDLE;
          end
        end
        ST_STOP2: begin
          if (sample) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_o       <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      overflow_o   <= 1'b0;
      data_o       <= '0;
    end else begin
      push_o       <= good && !fifo_full_i;
      overflow_o   <= good && fifo_full_i;
      frame_err_o  <= done && done_fe;
      parity_err_o <= done && !done_fe && par_bad;
      if (good && !fifo_full_i) data_o <= shreg;
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int unsigned DIV_W       = 12,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              stop_two_i,
  input  logic              word7_i,
  input  logic [2:0]        parity_sel_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              overflow_o
);

  logic line;
  logic fall;
  logic tick;
  logic busy;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .line_o (line),
    .fall_o (fall)
  );

  uart_rx_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!busy),
    .div_i  (divisor_i),
    .tick_o (tick)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) i_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_i       (line),
    .fall_i       (fall),
    .tick_i       (tick),
    .stop_two_i   (stop_two_i),
    .word7_i      (word7_i),
    .parity_sel_i (parity_sel_i),
    .fifo_full_i  (fifo_full_i),
    .busy_o       (busy),
    .push_o       (push_o),
    .data_o       (data_o),
    .frame_err_o  (frame_err_o),
    .parity_err_o (parity_err_o),
    .overflow_o   (overflow_o)
  );

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_full_i,
  input logic              word7_i,
  input logic              push_o,
  input logic [DATA_W-1:0] data_o,
  input logic              frame_err_o,
  input logic              parity_err_o,
  input logic              overflow_o
);

  a_r12_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_o, frame_err_o, parity_err_o, overflow_o}));

  a_r12_push_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  a_r12_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o || parity_err_o || overflow_o) |=> !(frame_err_o || parity_err_o || overflow_o));

  a_r10_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(fifo_full_i));

  a_r10_overflow_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(fifo_full_i));

  a_r3_msb_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && $past(word7_i)) |-> !data_o[DATA_W-1]);

  a_r2_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> push_o);

endmodule

bind uart_rx_core uart_rx_checker #(.DATA_W(DATA_W)) i_uart_rx_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_full_i  (fifo_full_i),
  .word7_i      (word7_i),
  .push_o       (push_o),
  .data_o       (data_o),
  .frame_err_o  (frame_err_o),
  .parity_err_o (parity_err_o),
  .overflow_o   (overflow_o)
);

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
module test_uart_rx_core;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_i = 1'b1;
  logic [11:0] divisor_i = 12'd4;
  logic        stop_two_i = 1'b0;
  logic        word7_i = 1'b0;
  logic [2:0]  parity_sel_i = 3'b000;
  logic        fifo_full_i = 1'b0;
  logic        push_o;
  logic [7:0]  data_o;
  logic        frame_err_o;
  logic        parity_err_o;
  logic        overflow_o;

  int n_checks = 0;
  int n_errors = 0;
  int c_push = 0, c_fe = 0, c_pe = 0, c_ov = 0;
  logic [7:0] last_data = 8'h00;

  always #4 clk_i = ~clk_i;

  uart_rx_core i_uart_rx_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .divisor_i(divisor_i),
    .stop_two_i(stop_two_i), .word7_i(word7_i), .parity_sel_i(parity_sel_i),
    .fifo_full_i(fifo_full_i), .push_o(push_o), .data_o(data_o),
    .frame_err_o(frame_err_o), .parity_err_o(parity_err_o), .overflow_o(overflow_o)
  );

  always @(negedge clk_i) begin
    if (push_o) begin c_push++; last_data = data_o; end
    if (frame_err_o)  c_fe++;
    if (parity_err_o) c_pe++;
    if (overflow_o)   c_ov++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * 16 * int'(divisor_i)) @(negedge clk_i);
  endtask

  function automatic logic par_on(input logic [2:0] ps);
    return ps >= 3'd1 && ps <= 3'd4;
  endfunction

  function automatic logic par_bit(input logic [2:0] ps, input logic [7:0] d, input logic w7);
    logic x;
    x = w7 ? ^d[6:0] : ^d;
    case (ps)
      3'd1: return ~x;
      3'd2: return x;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // bad_stop: 0 none, 1 first stop low, 2 second stop low
  task automatic send_frame(input string req, input logic [7:0] d, input int div,
                            input logic two, input logic w7, input logic [2:0] ps,
                            input logic bad_par, input int bad_stop, input logic full);
    int p0, f0, e0, o0;
    logic fe, pe, ov, ok;
    @(negedge clk_i);
    divisor_i = 12'(div); stop_two_i = two; word7_i = w7;
    parity_sel_i = ps; fifo_full_i = full;
    p0 = c_push; f0 = c_fe; e0 = c_pe; o0 = c_ov;
    rx_i = 1'b0; wait_bits(1);
    for (int i = 0; i < (w7 ? 7 : 8); i++) begin rx_i = d[i]; wait_bits(1); end
    if (par_on(ps)) begin rx_i = par_bit(ps, d, w7) ^ bad_par; wait_bits(1); end
    rx_i = (bad_stop == 1) ? 1'b0 : 1'b1; wait_bits(1);
    if (two) begin rx_i = (bad_stop == 2) ? 1'b0 : 1'b1; wait_bits(1); end
    rx_i = 1'b1; wait_bits(2);
    fe = (bad_stop == 1) || (two && bad_stop == 2);
    pe = !fe && par_on(ps) && bad_par;
    ov = !fe && !pe && full;
    ok = !fe && !pe && !full;
    check({req, " push"},   c_push - p0, int'(ok));
    check({req, " frame"},  c_fe - f0,   int'(fe));
    check({req, " parity"}, c_pe - e0,   int'(pe));
    check({req, " ovf"},    c_ov - o0,   int'(ov));
    if (ok) check({req, " data"}, int'(last_data), int'(w7 ? {1'b0, d[6:0]} : d));
    fifo_full_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int seed;
    int p0, f0, e0, o0;
    seed = $urandom(32'd20240611);
    repeat (5) @(negedge clk_i);
    check("R1 rst push", int'(push_o), 0);
    check("R1 rst data", int'(data_o), 0);
    rst_ni = 1'b1;
    repeat (100) @(negedge clk_i);
    check("R1 idle events", c_push + c_fe + c_pe + c_ov, 0);

    send_frame("R2 8N1",          8'hA5, 4, 0, 0, 3'd0, 0, 0, 0);
    send_frame("R2 div1",         8'h3C, 1, 0, 0, 3'd0, 0, 0, 0);
    send_frame("R3 7bit",         8'hD3, 3, 0, 1, 3'd0, 0, 0, 0);
    send_frame("R4 two stop ok",  8'h5A, 2, 1, 0, 3'd0, 0, 0, 0);
    send_frame("R4 second stop",  8'h5A, 2, 1, 0, 3'd0, 0, 2, 0);
    send_frame("R4 one stop",     8'h11, 2, 0, 0, 3'd0, 0, 2, 0);
    send_frame("R5 odd",          8'h07, 2, 0, 0, 3'd1, 0, 0, 0);
    send_frame("R5 even",         8'h07, 2, 0, 0, 3'd2, 0, 0, 0);
    send_frame("R6 mark",         8'h80, 2, 0, 0, 3'd3, 0, 0, 0);
    send_frame("R6 space",        8'h01, 2, 0, 0, 3'd4, 0, 0, 0);
    send_frame("R6 mark bad",     8'h80, 2, 0, 0, 3'd3, 1, 0, 0);
    send_frame("R7 code6",        8'hC9, 2, 0, 0, 3'd6, 0, 0, 0);
    send_frame("R7 code5 7bit",   8'h2B, 2, 0, 1, 3'd5, 0, 0, 0);
    send_frame("R8 stop low",     8'hFF, 2, 0, 0, 3'd0, 0, 1, 0);
    send_frame("R8 over parity",  8'h12, 2, 0, 0, 3'd2, 1, 1, 0);
    send_frame("R9 even bad",     8'h12, 2, 0, 0, 3'd2, 1, 0, 0);
    send_frame("R10 full",        8'h77, 2, 0, 0, 3'd0, 0, 0, 1);
    send_frame("R2 after full",   8'h78, 2, 0, 0, 3'd0, 0, 0, 0);

    // R11 glitch shorter than half a bit
    @(negedge clk_i);
    divisor_i = 12'd3;
    p0 = c_push; f0 = c_fe; e0 = c_pe; o0 = c_ov;
    rx_i = 1'b0; repeat (3 * 3) @(negedge clk_i);
    rx_i = 1'b1; wait_bits(14);
    check("R11 glitch events", (c_push - p0) + (c_fe - f0) + (c_pe - e0) + (c_ov - o0), 0);
    check("R11 glitch data", int'(last_data), 8'h78);
    send_frame("R11 after glitch", 8'h9E, 3, 0, 0, 3'd0, 0, 0, 0);

    for (int k = 0; k < 30; k++) begin
      logic [7:0] d;
      int div, bs;
      logic two, w7, bp, full;
      logic [2:0] ps;
      d    = 8'($urandom);
      div  = 1 + int'($urandom % 4);
      two  = 1'($urandom);
      w7   = 1'($urandom);
      ps   = 3'($urandom);
      bp   = ($urandom % 5) == 0;
      bs   = (($urandom % 5) == 0) ? 1 + int'($urandom % 2) : 0;
      full = ($urandom % 6) == 0;
      send_frame("R12 random", d, div, two, w7, ps, bp, bs, full);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule